// File: doc/BRIEF.md
# Segment Relocation and Limit Checker

This block holds a hidden cache of six segment descriptors. Each entry carries a base, a limit and an attribute byte. The block turns an effective address, which is an offset within a segment, into a linear address. It also decides whether the bytes touched by the access stay inside the segment limit. The linear address comes from one adder that adds the cached base to the offset. The limit decision comes from a second adder that subtracts the offset from the cached limit. Shallow logic on that difference then judges whether the remaining room covers the access size. Both adders work side by side in the same cycle.

Entries change only through two load ports. The protected load writes base, limit and attributes exactly as supplied. The real-mode load takes a 16-bit selector value and writes only the base, as the selector shifted left by four. Limit and attributes stay untouched, so a limit raised earlier by a protected load survives a later real-mode load. An access never re-reads anything from memory. It uses whatever the cache holds. Each access result is registered and appears one cycle after the request.

Top module: `seg_reloc_unit`

## Requirements
- R1: After reset every one of the six entries has base 0, limit 0x0000FFFF and attributes 0.
- R2: The linear address equals the cached base plus the offset, modulo 2^32.
- R3: `acc_size` carries the access length in bytes minus one: 0 means byte, 1 means word and 3 means dword. An access is legal only when offset + length − 1 ≤ limit, and `res_fault` is 1 exactly when it is not legal. For example, a dword at 0x100 needs a limit of at least 0x103.
- R4: An offset greater than the limit always faults, whatever the size. This includes offsets near 2^32, where offset + length − 1 would wrap.
- R5: A protected load writes base, limit and attributes as supplied into the chosen entry. Accesses issued after the load's clock edge see the new values.
- R6: A real-mode load sets the base of the chosen entry to the selector value shifted left by 4 and zero-extended. It leaves that entry's limit and attributes unchanged.
- R7: A limit raised by a protected load persists after a later real-mode load to the same entry.
- R8: A load changes only the entry it names. A load to index 6 or 7 changes no entry.
- R9: When both loads target the same entry in the same cycle, the protected load wins.
- R10: An access with index 6 or 7 returns `res_fault` = 1 and a linear address equal to the offset.
- R11: `res_valid` is 1 exactly one cycle after a cycle with `acc_valid` = 1, and 0 otherwise. `res_linear`, `res_fault` and `res_attr` hold their values in cycles without a request.
- R12: `res_attr` returns the cached attributes of the accessed entry, or 0 for index 6 or 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pm_ld_en | input | 1 | Protected load strobe |
| pm_ld_idx | input | 3 | Protected load entry index |
| pm_ld_base | input | 32 | Base to write |
| pm_ld_limit | input | 32 | Limit to write |
| pm_ld_attr | input | 8 | Attributes to write |
| rm_ld_en | input | 1 | Real-mode load strobe |
| rm_ld_idx | input | 3 | Real-mode load entry index |
| rm_ld_sel | input | 16 | Selector value for the base |
| acc_valid | input | 1 | Access request |
| acc_idx | input | 3 | Segment entry of the access |
| acc_offset | input | 32 | Effective address offset |
| acc_size | input | 2 | Access length in bytes minus one |
| res_valid | output | 1 | Result valid, one cycle after request |
| res_linear | output | 32 | Linear address |
| res_fault | output | 1 | Limit fault |
| res_attr | output | 8 | Attributes of the accessed entry |

## Verification
A load takes effect at the clock edge on which its strobe is sampled. The bench therefore raises a strobe at a falling edge and drops it at the next falling edge, and it issues the first dependent access only after that. An access result is due at the rising edge after the request. The bench reads `res_linear`, `res_fault` and `res_attr` at the falling edge that follows, which is the point where they have settled. In the back-to-back and idle cases, the bench checks at each falling edge that the result belongs to the request of the previous cycle and that it holds when no request came.

// File: rtl/seg_pkg.sv
package seg_pkg;
    parameter int NSEG  = 6;
    parameter int AW    = 32;
    parameter int SELW  = 16;
    parameter int ATTRW = 8;
    localparam int IDXW = $clog2(NSEG + 1);
    localparam int PADW = AW - SELW - 4;
    localparam logic [AW-1:0] RESET_LIMIT = AW'(32'h0000_FFFF);

    typedef struct packed {
        logic [AW-1:0]    base;
        logic [AW-1:0]    limit;
        logic [ATTRW-1:0] attr;
    } seg_entry_t;

    localparam seg_entry_t ENTRY_RESET = '{base: '0, limit: RESET_LIMIT, attr: '0};
    localparam seg_entry_t ENTRY_NONE  = '{base: '0, limit: '0, attr: '0};

    function automatic logic [AW-1:0] real_base(input logic [SELW-1:0] sel);
        return {{PADW{1'b0}}, sel, 4'b0000};
    endfunction

    function automatic logic idx_mapped(input logic [IDXW-1:0] idx);
        return int'(idx) < NSEG;
    endfunction
endpackage

// File: rtl/seg_desc_store.sv
module seg_desc_store
    import seg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             pm_en,
    input  logic [IDXW-1:0]  pm_idx,
    input  seg_entry_t       pm_entry,
    input  logic             rm_en,
    input  logic [IDXW-1:0]  rm_idx,
    input  logic [SELW-1:0]  rm_sel,
    input  logic [IDXW-1:0]  rd_idx,
    output seg_entry_t       rd_entry,
    output logic             rd_hit
);
    seg_entry_t entries [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_entry
        localparam logic [IDXW-1:0] MY_IDX = IDXW'(g);
        always_ff @(posedge clk) begin
            if (rst) begin
                entries[g] <= ENTRY_RESET;
            end else if (pm_en && pm_idx == MY_IDX) begin
                entries[g] <= pm_entry;
            end else if (rm_en && rm_idx == MY_IDX) begin
                entries[g].base <= real_base(rm_sel);
            end
        end
    end

    always_comb begin
        rd_hit   = idx_mapped(rd_idx);
        rd_entry = ENTRY_NONE;
        for (int k = 0; k < NSEG; k++) begin
            if (rd_idx == IDXW'(k)) rd_entry = entries[k];
        end
    end
endmodule

// File: rtl/seg_room_check.sv
module seg_room_check
    import seg_pkg::*;
(
    input  logic [AW-1:0] limit,
    input  logic [AW-1:0] offset,
    input  logic [1:0]    size_m1,
    output logic          fault
);
    logic [AW:0] room;
    logic        borrow;
    logic        wide_room;

    always_comb begin
        room      = {1'b0, limit} - {1'b0, offset};
        borrow    = room[AW];
        wide_room = |room[AW-1:2];
        fault     = borrow || (!wide_room && (room[1:0] < size_m1));
    end
endmodule

// File: rtl/seg_relocator.sv
module seg_relocator
    import seg_pkg::*;
(
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] offset,
    output logic [AW-1:0] linear
);
    assign linear = base + offset;
endmodule

// File: rtl/seg_reloc_unit.sv
module seg_reloc_unit
    import seg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 pm_ld_en,
    input  logic [IDXW-1:0]      pm_ld_idx,
    input  logic [AW-1:0]        pm_ld_base,
    input  logic [AW-1:0]        pm_ld_limit,
    input  logic [ATTRW-1:0]     pm_ld_attr,
    input  logic                 rm_ld_en,
    input  logic [IDXW-1:0]      rm_ld_idx,
    input  logic [SELW-1:0]      rm_ld_sel,
    input  logic                 acc_valid,
    input  logic [IDXW-1:0]      acc_idx,
    input  logic [AW-1:0]        acc_offset,
    input  logic [1:0]           acc_size,
    output logic                 res_valid,
    output logic [AW-1:0]        res_linear,
    output logic                 res_fault,
    output logic [ATTRW-1:0]     res_attr
);
    seg_entry_t pm_entry;
    seg_entry_t cur;
    logic       hit;
    logic       room_fault;
    logic [AW-1:0] lin_next;

    assign pm_entry = '{base: pm_ld_base, limit: pm_ld_limit, attr: pm_ld_attr};

    seg_desc_store i_store (
        .clk      (clk),
        .rst      (rst),
        .pm_en    (pm_ld_en),
        .pm_idx   (pm_ld_idx),
        .pm_entry (pm_entry),
        .rm_en    (rm_ld_en),
        .rm_idx   (rm_ld_idx),
        .rm_sel   (rm_ld_sel),
        .rd_idx   (acc_idx),
        .rd_entry (cur),
        .rd_hit   (hit)
    );

    seg_relocator i_reloc (
        .base   (cur.base),
        .offset (acc_offset),
        .linear (lin_next)
    );

    seg_room_check i_room (
        .limit   (cur.limit),
        .offset  (acc_offset),
        .size_m1 (acc_size),
        .fault   (room_fault)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid  <= 1'b0;
            res_linear <= '0;
            res_fault  <= 1'b0;
            res_attr   <= '0;
        end else begin
            res_valid <= acc_valid;
            if (acc_valid) begin
                res_linear <= lin_next;
                res_fault  <= room_fault || !hit;
                res_attr   <= cur.attr;
            end
        end
    end
endmodule

// File: rtl/seg_reloc_checker.sv
module seg_reloc_checker
    import seg_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            acc_valid,
    input logic [IDXW-1:0] acc_idx,
    input logic [AW-1:0]   acc_offset,
    input logic [1:0]      acc_size,
    input logic            res_valid,
    input logic [AW-1:0]   res_linear,
    input logic            res_fault
);
    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        acc_valid |=> res_valid); // R11
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> !res_valid); // R11
    AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |=> ($stable(res_linear) && $stable(res_fault))); // R11
    AST_UNMAPPED_FAULT: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !idx_mapped(acc_idx)) |=> res_fault); // R10
    AST_UNMAPPED_LINEAR: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && !idx_mapped(acc_idx)) |=> (res_linear == $past(acc_offset))); // R10
    AST_FIRST_BYTE_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && idx_mapped(acc_idx) && acc_offset == '0 && acc_size == 2'd0) |=> !res_fault); // R3
    AST_TOP_OFFSET_FAULT: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_offset == '1 && acc_size != 2'd0) |=> res_fault); // R4
endmodule

bind seg_reloc_unit seg_reloc_checker i_seg_reloc_checker (
    .clk        (clk),
    .rst        (rst),
    .acc_valid  (acc_valid),
    .acc_idx    (acc_idx),
    .acc_offset (acc_offset),
    .acc_size   (acc_size),
    .res_valid  (res_valid),
    .res_linear (res_linear),
    .res_fault  (res_fault)
);

// File: tb/test_seg_reloc_unit.sv
module test_seg_reloc_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pm_ld_en = 1'b0;
    logic [2:0]  pm_ld_idx = '0;
    logic [31:0] pm_ld_base = '0;
    logic [31:0] pm_ld_limit = '0;
    logic [7:0]  pm_ld_attr = '0;
    logic        rm_ld_en = 1'b0;
    logic [2:0]  rm_ld_idx = '0;
    logic [15:0] rm_ld_sel = '0;
    logic        acc_valid = 1'b0;
    logic [2:0]  acc_idx = '0;
    logic [31:0] acc_offset = '0;
    logic [1:0]  acc_size = '0;
    logic        res_valid;
    logic [31:0] res_linear;
    logic        res_fault;
    logic [7:0]  res_attr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [31:0] eb [6];
    logic [31:0] el [6];
    logic [7:0]  ea [6];

    always #2 clk = ~clk;

    seg_reloc_unit i_seg_reloc_unit (
        .clk(clk), .rst(rst),
        .pm_ld_en(pm_ld_en), .pm_ld_idx(pm_ld_idx), .pm_ld_base(pm_ld_base),
        .pm_ld_limit(pm_ld_limit), .pm_ld_attr(pm_ld_attr),
        .rm_ld_en(rm_ld_en), .rm_ld_idx(rm_ld_idx), .rm_ld_sel(rm_ld_sel),
        .acc_valid(acc_valid), .acc_idx(acc_idx), .acc_offset(acc_offset), .acc_size(acc_size),
        .res_valid(res_valid), .res_linear(res_linear), .res_fault(res_fault), .res_attr(res_attr)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    function automatic logic exp_fault(input logic [31:0] lim, input logic [31:0] off, input logic [1:0] sz);
        logic [33:0] last;
        last = {2'b00, off} + {32'b0, sz};
        return last > {2'b00, lim};
    endfunction

    task automatic pm_load(input logic [2:0] idx, input logic [31:0] b, input logic [31:0] l, input logic [7:0] a);
        @(negedge clk);
        pm_ld_en = 1'b1; pm_ld_idx = idx; pm_ld_base = b; pm_ld_limit = l; pm_ld_attr = a;
        @(negedge clk);
        pm_ld_en = 1'b0;
        if (idx < 3'd6) begin eb[idx] = b; el[idx] = l; ea[idx] = a; end
    endtask

    task automatic rm_load(input logic [2:0] idx, input logic [15:0] sel);
        @(negedge clk);
        rm_ld_en = 1'b1; rm_ld_idx = idx; rm_ld_sel = sel;
        @(negedge clk);
        rm_ld_en = 1'b0;
        if (idx < 3'd6) eb[idx] = {12'b0, sel, 4'b0};
    endtask

    task automatic access(input logic [2:0] idx, input logic [31:0] off, input logic [1:0] sz);
        @(negedge clk);
        acc_valid = 1'b1; acc_idx = idx; acc_offset = off; acc_size = sz;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic access_check(input string req, input logic [2:0] idx, input logic [31:0] off, input logic [1:0] sz);
        access(idx, off, sz);
        chk({req, " valid"}, {31'b0, res_valid}, 32'd1);
        if (idx < 3'd6) begin
            chk({req, " linear"}, res_linear, eb[idx] + off);
            chk({req, " fault"}, {31'b0, res_fault}, {31'b0, exp_fault(el[idx], off, sz)});
            chk({req, " attr"}, {24'b0, res_attr}, {24'b0, ea[idx]});
        end else begin
            chk({req, " linear"}, res_linear, off);
            chk({req, " fault"}, {31'b0, res_fault}, 32'd1);
            chk({req, " attr"}, {24'b0, res_attr}, 32'd0);
        end
    endtask

    task automatic t_reset;
        chk("R11 reset valid", {31'b0, res_valid}, 32'd0);
        for (int k = 0; k < 6; k++) begin
            access_check("R1 top byte", 3'(k), 32'h0000_FFFF, 2'd0);
            access_check("R1 beyond", 3'(k), 32'h0001_0000, 2'd0);
        end
        access_check("R3 word straddle", 3'd0, 32'h0000_FFFF, 2'd1);
    endtask

    task automatic t_protected;
        pm_load(3'd2, 32'h1000_0000, 32'h0000_0103, 8'h5A);
        access_check("R5 dword at 0x100", 3'd2, 32'h0000_0100, 2'd3);
        access_check("R3 dword at 0x101", 3'd2, 32'h0000_0101, 2'd3);
        access_check("R3 word at 0x102", 3'd2, 32'h0000_0102, 2'd1);
        access_check("R3 byte at limit", 3'd2, 32'h0000_0103, 2'd0);
        access_check("R3 word at limit", 3'd2, 32'h0000_0103, 2'd1);
        access_check("R4 byte past limit", 3'd2, 32'h0000_0104, 2'd0);
        access_check("R12 attr", 3'd2, 32'h0000_0000, 2'd0);
        pm_load(3'd3, 32'hFFFF_FFF0, 32'hFFFF_FFFF, 8'h33);
        access_check("R2 wrap", 3'd3, 32'h0000_0020, 2'd3);
        access_check("R3 dword near top", 3'd3, 32'hFFFF_FFFC, 2'd3);
        access_check("R4 dword over top", 3'd3, 32'hFFFF_FFFD, 2'd3);
        access_check("R4 word at all ones", 3'd3, 32'hFFFF_FFFF, 2'd1);
    endtask

    task automatic t_real;
        rm_load(3'd1, 16'h1234);
        access_check("R6 base", 3'd1, 32'h0000_0010, 2'd0);
        access_check("R6 limit kept", 3'd1, 32'h0000_FFFF, 2'd0);
        access_check("R6 limit kept beyond", 3'd1, 32'h0001_0000, 2'd0);
        rm_load(3'd3, 16'hABCD);
        access_check("R7 raised limit", 3'd3, 32'h0020_0000, 2'd3);
        chk("R7 linear", res_linear, 32'h002A_BCD0);
        chk("R6 attr kept", {24'b0, res_attr}, 32'h33);
    endtask

    task automatic t_isolation;
        pm_load(3'd6, 32'hDEAD_0000, 32'h0, 8'hEE);
        rm_load(3'd7, 16'hBEEF);
        for (int k = 0; k < 6; k++) begin
            access_check("R8 entry untouched", 3'(k), 32'h0000_0004, 2'd3);
            access_check("R8 limit untouched", 3'(k), el[k], 2'd0);
        end
    endtask

    task automatic t_collide;
        @(negedge clk);
        pm_ld_en = 1'b1; pm_ld_idx = 3'd4; pm_ld_base = 32'h0000_4000; pm_ld_limit = 32'h20; pm_ld_attr = 8'h77;
        rm_ld_en = 1'b1; rm_ld_idx = 3'd4; rm_ld_sel = 16'h0009;
        @(negedge clk);
        pm_ld_en = 1'b0; rm_ld_en = 1'b0;
        eb[4] = 32'h0000_4000; el[4] = 32'h20; ea[4] = 8'h77;
        access_check("R9 protected wins", 3'd4, 32'h0000_0020, 2'd0);
        access_check("R9 limit from protected", 3'd4, 32'h0000_0021, 2'd0);
    endtask

    task automatic t_unmapped;
        access_check("R10 index 6", 3'd6, 32'h0000_0055, 2'd0);
        access_check("R10 index 7", 3'd7, 32'h0000_0000, 2'd0);
    endtask

    task automatic t_timing;
        logic [31:0] held;
        @(negedge clk);
        acc_valid = 1'b1; acc_idx = 3'd2; acc_offset = 32'h0000_0010; acc_size = 2'd0;
        @(negedge clk);
        chk("R11 first of pair", res_linear, 32'h1000_0010);
        acc_idx = 3'd1; acc_offset = 32'h0000_0200; acc_size = 2'd1;
        @(negedge clk);
        acc_valid = 1'b0;
        chk("R11 second of pair", res_linear, 32'h0001_2540);
        chk("R11 second valid", {31'b0, res_valid}, 32'd1);
        held = res_linear;
        acc_offset = 32'h0000_0FFF; acc_idx = 3'd0;
        @(negedge clk);
        chk("R11 idle valid", {31'b0, res_valid}, 32'd0);
        chk("R11 idle hold", res_linear, held);
        chk("R11 idle fault hold", {31'b0, res_fault}, 32'd0);
    endtask

    initial begin
        for (int k = 0; k < 6; k++) begin eb[k] = '0; el[k] = 32'h0000_FFFF; ea[k] = '0; end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_protected();
        t_real();
        t_isolation();
        t_collide();
        t_unmapped();
        t_timing();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule